// File: doc/BRIEF.md
# Dual-Rate Integrating ADC Conversion Sequencer

This block runs the digital side of one integrating analog-to-digital conversion. A start strobe begins an integrate phase whose length comes from a two-bit resolution code. The block then discharges the integrator in two steps: first with a coarse, fast reference, then with a fine, slow reference. The handover happens when a near-zero comparator reports that little charge is left. The slow step ends when a zero-crossing comparator fires.

Cycles spent in the coarse step are weighted 64 and cycles in the fine step are weighted 1. The weighted total is published together with a sign and an overload flag. The sign is the input polarity seen at the end of integration. The overload flag reports either an over-range event during integration or a run-down that took too long. The analog switches are driven directly from registered enable outputs.

Top module: `adc_dual_rate_seq`

## Requirements
- R1: After reset, every enable output, busy, done, count, sign and overload are 0.
- R2: start is accepted only while the block is idle, meaning busy is low and no conversion is ending. A start at any other time has no effect on the sequence or on the published results.
- R3: The resolution code is sampled when start is accepted. Code 0 selects LEN_LO integrate cycles, code 1 selects LEN_MID, code 2 selects LEN_HI, and code 3 selects LEN_LO. integ_en is high for exactly that many cycles, starting the cycle after start is taken. Changing the code later has no effect.
- R4: fast_ref_en rises in the cycle integ_en falls. It stays high up to and including the cycle in which near_zero_det is sampled high, and slow_ref_en follows in the next cycle. near_zero_det is ignored outside the coarse phase.
- R5: slow_ref_en stays high up to and including the cycle in which zero_cross_det is sampled high. zero_cross_det is ignored outside the fine phase. busy falls at the next edge, and done is high for exactly one cycle, one cycle later.
- R6: When done is high, count equals FAST_WT (64) times the number of cycles fast_ref_en was high, plus the number of cycles slow_ref_en was high.
- R7: sign equals the pol_in value sampled in the last integrate cycle.
- R8: overload is 1 if ovr_det was high in any integrate cycle. ovr_det outside integration has no effect.
- R9: If either run-down phase lasts twice the selected integrate length without its comparator firing, the conversion ends as in R5 with overload set. A comparator that fires in that final cycle takes priority over the time-out.
- R10: At most one of integ_en, fast_ref_en and slow_ref_en is high in any cycle.
- R11: count, sign and overload change only at the edge that raises done, and they hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request strobe |
| res_sel | input | 2 | Resolution code selecting the integrate length |
| ovr_det | input | 1 | Over-range comparator |
| near_zero_det | input | 1 | Near-zero comparator (ends the coarse run-down) |
| zero_cross_det | input | 1 | Zero-crossing comparator (ends the fine run-down) |
| pol_in | input | 1 | Input polarity flag |
| integ_en | output | 1 | Input switch enable during integration |
| fast_ref_en | output | 1 | Coarse discharge reference enable |
| slow_ref_en | output | 1 | Fine discharge reference enable |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| count | output | RW | Weighted run-down result |
| sign | output | 1 | Result polarity |
| overload | output | 1 | Over-range or time-out indicator |

## Verification
Several properties are checked on every cycle: the switch enables never overlap, done is a single-cycle pulse while busy is low, and the coarse phase always follows integration. The fine phase is entered only from the coarse phase, the published results hold between done pulses, and the phase timer never passes its limit. Other behaviour only shows up in the bench scenarios: the exact integrate length for each resolution code, the weighted count, the polarity capture point, and the time-out path with its overload flag. The same applies to ignored starts, to comparator pulses outside their own phase, and to a resolution code changed mid-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INTEG = 3'd1,
    ST_FAST  = 3'd2,
    ST_SLOW  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  function automatic logic in_phase(input seq_state_t s);
    return (s == ST_INTEG) || (s == ST_FAST) || (s == ST_SLOW);
  endfunction

endpackage

// File: rtl/adc_len_sel.sv
module adc_len_sel #(
  parameter int CW      = 18,
  parameter int LEN_LO  = 1000,
  parameter int LEN_MID = 10000,
  parameter int LEN_HI  = 100000
) (
  input  logic [1:0]    res_sel,
  output logic [CW-1:0] int_len,
  output logic [CW-1:0] tmo_len
);

  always_comb begin
    case (res_sel)
      2'd1:    int_len = CW'(LEN_MID);
      2'd2:    int_len = CW'(LEN_HI);
      default: int_len = CW'(LEN_LO);
    endcase
    tmo_len = int_len << 1;
  end

endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (en)      cnt <= cnt + 1'b1;
  end

  assign hit = en && (cnt == limit - 1'b1);

  // R9: a phase never runs past its cycle budget
  assert_timer_bound_R9: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < limit));

endmodule

// File: rtl/adc_rundown_acc.sv
module adc_rundown_acc #(
  parameter int RW      = 24,
  parameter int FAST_WT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          add_fast,
  input  logic          add_slow,
  output logic [RW-1:0] acc
);

  localparam logic [RW-1:0] WT_F = RW'(FAST_WT);
  localparam logic [RW-1:0] WT_S = RW'(1);

  always_ff @(posedge clk) begin
    if (rst || clear)  acc <= '0;
    else if (add_fast) acc <= acc + WT_F;
    else if (add_slow) acc <= acc + WT_S;
  end

endmodule

// File: rtl/adc_dual_rate_seq.sv
module adc_dual_rate_seq
  import adc_seq_pkg::*;
#(
  parameter int LEN_LO  = 1000,
  parameter int LEN_MID = 10000,
  parameter int LEN_HI  = 100000,
  parameter int FAST_WT = 64,
  parameter int RW      = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    res_sel,
  input  logic          ovr_det,
  input  logic          near_zero_det,
  input  logic          zero_cross_det,
  input  logic          pol_in,
  output logic          integ_en,
  output logic          fast_ref_en,
  output logic          slow_ref_en,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] count,
  output logic          sign,
  output logic          overload
);

  localparam int CW = $clog2(2 * LEN_HI + 1);

  seq_state_t    st, nxt;
  logic [CW-1:0] len_w, tmo_w, len_q, tmo_q, lim;
  logic          accept, hit, tmr_clr, tmo_fire;
  logic          ovl_q, sgn_q;
  logic [RW-1:0] acc;

  adc_len_sel #(.CW(CW), .LEN_LO(LEN_LO), .LEN_MID(LEN_MID), .LEN_HI(LEN_HI)) u_len (
    .res_sel (res_sel),
    .int_len (len_w),
    .tmo_len (tmo_w)
  );

  assign accept = (st == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      tmo_q <= '0;
    end else if (accept) begin
      len_q <= len_w;
      tmo_q <= tmo_w;
    end
  end

  assign lim     = (st == ST_INTEG) ? len_q : tmo_q;
  assign tmr_clr = (nxt != st);

  adc_phase_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clr),
    .en    (in_phase(st)),
    .limit (lim),
    .hit   (hit)
  );

  assign tmo_fire = ((st == ST_FAST) && !near_zero_det && hit) ||
                    ((st == ST_SLOW) && !zero_cross_det && hit);

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:  if (start) nxt = ST_INTEG;
      ST_INTEG: if (hit) nxt = ST_FAST;
      ST_FAST:  if (near_zero_det) nxt = ST_SLOW;
                else if (hit)      nxt = ST_DONE;
      ST_SLOW:  if (zero_cross_det || hit) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  adc_rundown_acc #(.RW(RW), .FAST_WT(FAST_WT)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .add_fast (st == ST_FAST),
    .add_slow (st == ST_SLOW),
    .acc      (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ovl_q <= 1'b0;
      sgn_q <= 1'b0;
    end else begin
      st <= nxt;
      if (accept) ovl_q <= 1'b0;
      else if (((st == ST_INTEG) && ovr_det) || tmo_fire) ovl_q <= 1'b1;
      if ((st == ST_INTEG) && hit) sgn_q <= pol_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_en    <= 1'b0;
      fast_ref_en <= 1'b0;
      slow_ref_en <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      count       <= '0;
      sign        <= 1'b0;
      overload    <= 1'b0;
    end else begin
      integ_en    <= (nxt == ST_INTEG);
      fast_ref_en <= (nxt == ST_FAST);
      slow_ref_en <= (nxt == ST_SLOW);
      busy        <= in_phase(nxt);
      done        <= (st == ST_DONE);
      if (st == ST_DONE) begin
        count    <= acc;
        sign     <= sgn_q;
        overload <= ovl_q;
      end
    end
  end

  // R10: switch enables are mutually exclusive
  assert_one_switch_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({integ_en, fast_ref_en, slow_ref_en}));

  // R5: done lasts one cycle and never overlaps busy
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4: coarse run-down directly follows integration; fine follows coarse
  assert_fast_after_int_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(integ_en) |-> fast_ref_en);
  assert_slow_after_fast_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_ref_en) |-> $past(fast_ref_en));

  // R2: once past integration, no restart until the sequence returns to idle
  assert_no_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !integ_en) |=> !integ_en);

  // R11: published results change only with done
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(count) && $stable(sign) && $stable(overload)));

endmodule

// File: tb/adc_dual_rate_seq_test.sv
`timescale 1ns/1ps
module adc_dual_rate_seq_test;

  localparam int L0 = 10, L1 = 20, L2 = 30, WT = 64, RW = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, ovr = 1'b0, nz = 1'b0, zc = 1'b0, pol = 1'b0;
  logic [1:0] res = 2'd0;
  logic integ_en, fast_ref_en, slow_ref_en, busy, done, sign, overload;
  logic [RW-1:0] count;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_dual_rate_seq #(.LEN_LO(L0), .LEN_MID(L1), .LEN_HI(L2), .FAST_WT(WT), .RW(RW)) uut (
    .clk(clk), .rst(rst), .start(start), .res_sel(res), .ovr_det(ovr),
    .near_zero_det(nz), .zero_cross_det(zc), .pol_in(pol),
    .integ_en(integ_en), .fast_ref_en(fast_ref_en), .slow_ref_en(slow_ref_en),
    .busy(busy), .done(done), .count(count), .sign(sign), .overload(overload)
  );

  function automatic int len_of(input logic [1:0] r);
    if (r == 2'd1) return L1;
    if (r == 2'd2) return L2;
    return L0;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase code 0 idle,1 integrate,2 coarse,3 fine,4 ending
  int m_ph = 0, m_cnt = 0, m_len = 0;
  longint m_acc = 0;
  bit m_sgn = 0, m_ovl = 0;
  bit e_int = 0, e_fast = 0, e_slow = 0, e_busy = 0, e_done = 0, e_sign = 0, e_ovl = 0;
  longint e_res = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_acc = 0; m_sgn = 0; m_ovl = 0;
      e_done = 0; e_res = 0; e_sign = 0; e_ovl = 0;
    end else begin
      e_done = 0;
      case (m_ph)
        0: if (start) begin m_ph = 1; m_cnt = 0; m_len = len_of(res); m_acc = 0; m_ovl = 0; end
        1: begin
          if (ovr) m_ovl = 1;
          m_cnt++;
          if (m_cnt == m_len) begin m_sgn = pol; m_ph = 2; m_cnt = 0; end
        end
        2: begin
          m_acc += WT; m_cnt++;
          if (nz) begin m_ph = 3; m_cnt = 0; end
          else if (m_cnt == 2 * m_len) begin m_ovl = 1; m_ph = 4; end
        end
        3: begin
          m_acc += 1; m_cnt++;
          if (zc) m_ph = 4;
          else if (m_cnt == 2 * m_len) begin m_ovl = 1; m_ph = 4; end
        end
        default: begin e_done = 1; e_res = m_acc; e_sign = m_sgn; e_ovl = m_ovl; m_ph = 0; end
      endcase
    end
    e_int  = (m_ph == 1);
    e_fast = (m_ph == 2);
    e_slow = (m_ph == 3);
    e_busy = (m_ph >= 1 && m_ph <= 3);
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) if (!rst && !finished) begin
    check(integ_en == e_int,     "R3 integ_en", integ_en, e_int);
    check(fast_ref_en == e_fast, "R4 fast_ref_en", fast_ref_en, e_fast);
    check(slow_ref_en == e_slow, "R5 slow_ref_en", slow_ref_en, e_slow);
    check(busy == e_busy,        "R2 busy", busy, e_busy);
    check(done == e_done,        "R5 done", done, e_done);
    check(count == e_res,        "R6 count", count, e_res);
    check(sign == e_sign,        "R7 sign", sign, e_sign);
    check(overload == e_ovl,     "R8 overload", overload, e_ovl);
    check($countones({integ_en, fast_ref_en, slow_ref_en}) <= 1, "R10 exclusive",
          $countones({integ_en, fast_ref_en, slow_ref_en}), 1);
  end

  // ovr_at<0: no over-range; nf==0: coarse time-out; ns==0: fine time-out
  task automatic run_conv(input logic [1:0] r, input int ovr_at, input int nf,
                          input int ns, input bit p, input bit poke);
    int ic = 0, fc = 0, sc = 0, len;
    longint exp_cnt;
    bit exp_ovl;
    logic [RW-1:0] held;
    len = len_of(r);
    @(negedge clk); start = 1; res = r; pol = p;
    @(negedge clk); start = 0; res = ~r;
    while (!e_done) begin
      ovr   = (e_int && ic == ovr_at) || e_slow;
      start = poke && e_int && ic == 3;
      nz    = (e_fast && fc + 1 == nf) || e_int;
      zc    = (e_slow && sc + 1 == ns) || e_fast;
      pol   = e_int ? p : ~p;
      if (e_int) ic++;
      if (e_fast) fc++;
      if (e_slow) sc++;
      @(negedge clk);
    end
    ovr = 0; nz = 0; zc = 0; start = 0;
    exp_cnt = (nf == 0) ? longint'(WT) * 2 * len
                        : longint'(WT) * nf + ((ns == 0) ? 2 * len : ns);
    exp_ovl = (ovr_at >= 0 && ovr_at < len) || nf == 0 || ns == 0;
    check(done == 1'b1,        "R5 done pulse", done, 1);
    check(ic == len,           "R3 integrate length", ic, len);
    check(count == exp_cnt,    "R6 weighted count", count, exp_cnt);
    check(sign == p,           "R7 polarity", sign, p);
    check(overload == exp_ovl, "R8 R9 overload", overload, exp_ovl);
    held = count;
    @(negedge clk); start = 1; res = 2'd0;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    check(count == held, "R11 result hold", count, held);
    while (!e_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(integ_en == 0 && fast_ref_en == 0 && slow_ref_en == 0, "R1 enables", integ_en, 0);
    check(busy == 0 && done == 0, "R1 flags", busy, 0);
    check(count == 0 && sign == 0 && overload == 0, "R1 result", count, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(busy == 0 && count == 0, "R1 after release", busy, 0);
    run_conv(2'd0, -1, 3, 5, 1'b1, 1'b0);
    run_conv(2'd1, -1, 7, 2, 1'b0, 1'b1);   // R2 poke mid-integrate
    run_conv(2'd2, 29, 1, 1, 1'b1, 1'b0);   // R8 over-range in last integrate cycle
    run_conv(2'd3, 0, 4, 9, 1'b0, 1'b0);    // R3 reserved code
    run_conv(2'd0, -1, 0, 1, 1'b1, 1'b0);   // R9 coarse time-out
    run_conv(2'd1, -1, 2, 0, 1'b0, 1'b0);   // R9 fine time-out
    run_conv(2'd0, -1, 20, 20, 1'b1, 1'b0); // R9 comparators win on final cycle
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule